// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Aggregator

This block gathers level-sensitive interrupt lines in groups of 32, one group per bank, with the bank count set by a parameter. Each bank exposes a read-only view of its live input levels. It also holds three enable registers, one for each of three outputs: a normal interrupt line, a fast interrupt line and an endpoint line. A source reaches an output only while it is high and its bit is set in that output's enable register for its bank. Each output is the OR of those terms over every bank.

Software reaches the registers through a flat word-addressed port. Each bank owns a 16-byte window. The bank number is taken from the address bits above that window, and the two lowest address bits must be zero. As a convenience, the block also reports which source is the highest-numbered one pending on the normal interrupt line. Service routines take the most significant pending bit first, so they can read this index directly and skip the scan.

Top module: `multi_irq_ctrl`

## Requirements
- R1: After reset, all three enable registers in every bank read zero, and `irq_o`, `fiq_o` and `ept_o` are low.
- R2: A read at bank offset 0x0 returns that bank's 32 source levels as they are at that moment. Nothing is latched, so a source that drops reads back as zero.
- R3: Writes to offset 0x0 are ignored. No enable register changes.
- R4: Offset 0x4 holds the normal-line enable and can be read and written. `irq_o` is high exactly when some bank has a source bit that is high and also set in that bank's normal enable.
- R5: Offset 0x8 holds the fast-line enable. `fiq_o` is formed from it in the same way as `irq_o`.
- R6: Offset 0xC holds the endpoint enable. `ept_o` is formed from it in the same way as `irq_o`.
- R7: A write to one enable register leaves the other two enable registers of that bank unchanged.
- R8: Writing zero to an enable register silences its output for that bank, even while sources stay high.
- R9: Address bits [ADDR_W-1:4] pick the bank and bits [3:2] pick the register. An access to a bank number at or above NUM_BANKS, or with bits [1:0] nonzero, reads zero and writes nothing. A write to one bank never alters another bank.
- R10: `pend_valid` is high when any normal-line term is pending. `pend_index` then gives bank*32 + bit for the most significant pending term across all banks.
- R11: A write takes effect at the clock edge that samples it, so the new value reads back on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address: bank above bit 4, register in bits [3:2] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src | input | NUM_BANKS*32 | Level interrupt sources; bank b uses bits [b*32+31:b*32] |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| ept_o | output | 1 | Endpoint interrupt line |
| pend_valid | output | 1 | Some normal-line term is pending |
| pend_index | output | IDX_W | Highest pending normal-line source number |

## Verification
Several properties hold on every cycle and are checked that way. A write to the source view, or to another bank, leaves a bank's enables untouched. A write to one enable leaves its two siblings alone, and a fast-line write lands with the written value. With all sources low, all three outputs are low. Whenever `pend_valid` is high, the bit named by `pend_index` is the top set bit of the pending vector. Other behaviour can only be shown by the directed scenarios, because it needs a chosen sequence of writes and source patterns: that cause reads follow live levels, that each enable steers sources to its own output, that a zero write silences a line, that unmapped addresses read zero, and that the priority index moves as higher sources drop.

// File: rtl/mbic_pkg.sv
package mbic_pkg;
    localparam int SRC_PER_BANK = 32;
    localparam int WIN_BITS     = 4;

    typedef enum logic [1:0] {
        REG_CAUSE = 2'd0,
        REG_IRQM  = 2'd1,
        REG_FIQM  = 2'd2,
        REG_EPTM  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_PER_BANK-1:0] irq;
        logic [SRC_PER_BANK-1:0] fiq;
        logic [SRC_PER_BANK-1:0] ept;
    } mask_set_t;
endpackage

// File: rtl/mbic_msb_find.sv
module mbic_msb_find #(
    parameter int W     = 64,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] index_o
);
    always_comb begin
        valid_o = 1'b0;
        index_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                valid_o = 1'b1;
                index_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mbic_bank.sv
module mbic_bank
    import mbic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    wr_en,
    input  reg_sel_e                word,
    input  logic [31:0]             wdata,
    input  logic [SRC_PER_BANK-1:0] src,
    output logic [31:0]             rdata,
    output logic [SRC_PER_BANK-1:0] pend_irq,
    output logic [SRC_PER_BANK-1:0] pend_fiq,
    output logic [SRC_PER_BANK-1:0] pend_ept
);
    mask_set_t masks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            masks <= '0;
        end else if (sel && wr_en) begin
            case (word)
                REG_IRQM: masks.irq <= wdata;
                REG_FIQM: masks.fiq <= wdata;
                REG_EPTM: masks.ept <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (word)
            REG_CAUSE: rdata = src;
            REG_IRQM:  rdata = masks.irq;
            REG_FIQM:  rdata = masks.fiq;
            REG_EPTM:  rdata = masks.ept;
        endcase
    end

    assign pend_irq = src & masks.irq;
    assign pend_fiq = src & masks.fiq;
    assign pend_ept = src & masks.ept;

    // R3
    cause_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && word == REG_CAUSE) |=> $stable(masks));

    // R9
    unselected_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> $stable(masks));

    // R7
    irq_write_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && word == REG_IRQM) |=> ($stable(masks.fiq) && $stable(masks.ept)));

    // R11
    fiq_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && word == REG_FIQM) |=> (masks.fiq == $past(wdata)));
endmodule

// File: rtl/multi_irq_ctrl.sv
module multi_irq_ctrl
    import mbic_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8,
    localparam int TOTAL    = NUM_BANKS * SRC_PER_BANK,
    localparam int IDX_W    = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [TOTAL-1:0]  src,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              ept_o,
    output logic              pend_valid,
    output logic [IDX_W-1:0]  pend_index
);
    localparam int BIDX_W = ADDR_W - WIN_BITS;

    logic [BIDX_W-1:0]  bank_idx;
    logic               off_ok;
    reg_sel_e           word;
    logic [NUM_BANKS-1:0] sel_w;
    logic [31:0]        bank_rd [NUM_BANKS];
    logic [TOTAL-1:0]   vec_irq, vec_fiq, vec_ept;

    assign bank_idx = addr[ADDR_W-1:WIN_BITS];
    assign off_ok   = (addr[1:0] == 2'b00);
    assign word     = reg_sel_e'(addr[3:2]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sel_w[b] = off_ok && (bank_idx == BIDX_W'(b));

        mbic_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel_w[b]),
            .wr_en    (wr_en),
            .word     (word),
            .wdata    (wdata),
            .src      (src[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .rdata    (bank_rd[b]),
            .pend_irq (vec_irq[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .pend_fiq (vec_fiq[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .pend_ept (vec_ept[b*SRC_PER_BANK +: SRC_PER_BANK])
        );
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_w[b]) rdata = bank_rd[b];
        end
    end

    assign irq_o = |vec_irq;
    assign fiq_o = |vec_fiq;
    assign ept_o = |vec_ept;

    mbic_msb_find #(.W(TOTAL)) u_msb (
        .vec_i   (vec_irq),
        .valid_o (pend_valid),
        .index_o (pend_index)
    );

    // R4
    quiet_without_sources_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (!irq_o && !fiq_o && !ept_o));

    // R10
    index_is_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ((vec_irq >> pend_index) == TOTAL'(1)));
endmodule

// File: tb/multi_irq_ctrl_tb.sv
module multi_irq_ctrl_tb;
    localparam int NB  = 2;
    localparam int AW  = 8;
    localparam int TOT = NB * 32;
    localparam int IW  = $clog2(TOT);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [TOT-1:0] src = '0;
    logic          irq_o, fiq_o, ept_o, pend_valid;
    logic [IW-1:0] pend_index;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    multi_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src(src), .irq_o(irq_o), .fiq_o(fiq_o), .ept_o(ept_o),
        .pend_valid(pend_valid), .pend_index(pend_index)
    );

    function automatic logic [AW-1:0] ra(int bank, int off);
        return AW'(bank * 16 + off);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [AW-1:0] a, logic [31:0] exp, string req);
        addr = a;
        #1;
        check(rdata === exp, req, rdata, exp);
    endtask

    task automatic outs_chk(bit ei, bit ef, bit ee, string req);
        #1;
        check({irq_o, fiq_o, ept_o} === {ei, ef, ee}, req,
              32'({irq_o, fiq_o, ept_o}), 32'({ei, ef, ee}));
    endtask

    task automatic t_reset;
        for (int b = 0; b < NB; b++) begin
            rd_chk(ra(b, 4), 32'h0, "R1");
            rd_chk(ra(b, 8), 32'h0, "R1");
            rd_chk(ra(b, 12), 32'h0, "R1");
        end
        src = '1;
        outs_chk(0, 0, 0, "R1");
        src = '0;
    endtask

    task automatic t_cause;
        src = {32'h0000_8001, 32'hA5A5_0001};
        rd_chk(ra(0, 0), 32'hA5A5_0001, "R2");
        rd_chk(ra(1, 0), 32'h0000_8001, "R2");
        src[0] = 1'b0;
        rd_chk(ra(0, 0), 32'hA5A5_0000, "R2");
        wr(ra(0, 0), 32'hFFFF_FFFF);
        rd_chk(ra(0, 4), 32'h0, "R3");
        rd_chk(ra(0, 8), 32'h0, "R3");
        rd_chk(ra(0, 12), 32'h0, "R3");
        outs_chk(0, 0, 0, "R3");
        src = '0;
    endtask

    task automatic t_route;
        wr(ra(0, 4), 32'h0000_0001);
        rd_chk(ra(0, 4), 32'h0000_0001, "R11");
        src = 64'h1;
        outs_chk(1, 0, 0, "R4");
        wr(ra(1, 8), 32'h8000_0000);
        rd_chk(ra(0, 4), 32'h0000_0001, "R7");
        rd_chk(ra(1, 4), 32'h0, "R7");
        src = 64'h8000_0000_0000_0000;
        outs_chk(0, 1, 0, "R5");
        wr(ra(0, 12), 32'h0000_0010);
        rd_chk(ra(0, 4), 32'h0000_0001, "R7");
        src = 64'h10;
        outs_chk(0, 0, 1, "R6");
        src = 64'h8000_0000_0000_0011;
        outs_chk(1, 1, 1, "R4");
        wr(ra(0, 4), 32'h0);
        outs_chk(0, 1, 1, "R8");
        wr(ra(1, 8), 32'h0);
        wr(ra(0, 12), 32'h0);
        outs_chk(0, 0, 0, "R8");
        src = '0;
    endtask

    task automatic t_decode;
        wr(ra(1, 4), 32'h1234_5678);
        rd_chk(ra(0, 4), 32'h0, "R9");
        rd_chk(ra(1, 4), 32'h1234_5678, "R9");
        wr(ra(5, 4), 32'hFFFF_FFFF);
        rd_chk(ra(5, 4), 32'h0, "R9");
        rd_chk(ra(1, 4), 32'h1234_5678, "R9");
        rd_chk(ra(0, 4), 32'h0, "R9");
        wr(ra(1, 5), 32'h0);
        rd_chk(ra(1, 5), 32'h0, "R9");
        rd_chk(ra(1, 4), 32'h1234_5678, "R9");
    endtask

    task automatic t_index;
        wr(ra(0, 4), 32'hFFFF_FFFF);
        wr(ra(1, 4), 32'h0000_0F00);
        src = '0;
        #1;
        check(pend_valid === 1'b0, "R10", 32'(pend_valid), 32'h0);
        src = (64'h1 << 41) | (64'h1 << 3) | (64'h1 << 50);
        #1;
        check(pend_valid === 1'b1 && pend_index === IW'(41), "R10", 32'(pend_index), 32'd41);
        src[41] = 1'b0;
        #1;
        check(pend_valid === 1'b1 && pend_index === IW'(3), "R10", 32'(pend_index), 32'd3);
        src = 64'h1 << 31;
        #1;
        check(pend_index === IW'(31), "R10", 32'(pend_index), 32'd31);
        src = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cause();
        t_route();
        t_decode();
        t_index();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule